// File: doc/BRIEF.md
# Drive password lock controller

This block decides whether a storage device may touch its media. It takes security commands that an upstream decoder has already identified, each with a password, a selector that chooses between the master and the user credential, and a requested protection level. It keeps both passwords, a lock-enable flag and the protection level in storage that survives a power cycle. Session state is cleared on every power-on pulse: the locked flag, the frozen flag, the count of failed password attempts, and a mark showing whether an erase has been prepared.

Each command gets a one-cycle completion or abort pulse. A successful erase-unit command also pulses an erase request to the backend. Setting a user password does not lock the drive at once. The drive locks at the next power-on pulse, and from then on media access is refused until an unlock succeeds. When the user password is lost, recovery depends on the protection level. At High level the master password unlocks the drive. At Maximum level the only way back is an erase-unit command, which wipes the user data and removes the lock.

Top module: `pw_lock_ctrl`

## Requirements
- R1: After `rst_ni` (factory state) media access is permitted, the lock is disabled, the level is High and the master password is every byte 20h. Command codes are F1h set password, F2h unlock, F3h erase prepare, F4h erase unit, F5h freeze and F6h disable; any other code aborts.
- R2: Set password with `sel_master_i`=1 replaces only the master password and leaves the lock disabled, so media access is still permitted after a power-on pulse.
- R3: Set password with `sel_master_i`=0 stores the user password, enables the lock and records `level_max_i` (0 = High, 1 = Maximum). `media_ok_o` stays 1 until the next `por_i` pulse and is 0 after it.
- R4: While locked, `media_ok_o` is 0 and set password, freeze and disable all abort.
- R5: Unlock succeeds and sets `media_ok_o` to 1 when the user password matches. The master password also unlocks the drive, but only at High level.
- R6: At Maximum level, unlock with the master password aborts even when the password matches.
- R7: Erase unit aborts unless the command accepted just before it was a successful erase prepare. Any other command in between cancels the prepare.
- R8: Erase unit with a matching user password, or with the matching master password at either level, completes with `erase_req_o`=1 in the same cycle as `done_o`. It disables the lock, clears the user password and permits media access, and access stays permitted after a power-on pulse.
- R9: Freeze succeeds only when unlocked. Once frozen, set password, unlock, erase prepare, erase unit and disable abort until the next `por_i`.
- R10: A password mismatch in unlock, erase unit or disable aborts and adds one to an attempt counter. After 5 failures, unlock aborts even with the correct password until `por_i` clears the counter.
- R11: Disable, when unlocked and not frozen, clears the lock enable and the user password if the user password matches, or if the master password matches at High level. At Maximum level the master password aborts.
- R12: A command sampled at a rising edge produces exactly one of `done_o`/`abort_o` for the following cycle. No pulse appears without a command. A command presented together with `por_i` is dropped and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous factory reset, including stored state |
| por_i | input | 1 | Power-on pulse: clears session state and keeps stored state |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Security command code |
| pw_i | input | PW_BYTES*8 | Password supplied with the command |
| sel_master_i | input | 1 | 1 = master credential, 0 = user credential |
| level_max_i | input | 1 | Level for set user password: 1 = Maximum, 0 = High |
| media_ok_o | output | 1 | Media access permitted |
| done_o | output | 1 | Command completed |
| abort_o | output | 1 | Command aborted |
| erase_req_o | output | 1 | Erase request to the backend |

## Verification
The hardest state to reach is the attempt-counter limit combined with a stored lock. It needs a user password to be set, then a power-on pulse, then five mismatching unlocks, and only then does the bench show that the correct password is also refused. The Maximum-level recovery path also takes several steps. The bench locks the drive at Maximum level, shows that master unlock fails, and checks that an erase prepare cancelled by an intervening command leaves erase unit refused. It then runs a clean prepare and erase, which must succeed. An exhaustive sweep of every code outside F1h to F6h confirms that each of them aborts.

// File: rtl/pw_lock_pkg.sv
package pw_lock_pkg;
  typedef enum logic [7:0] {
    CMD_SET_PW     = 8'hF1,
    CMD_UNLOCK     = 8'hF2,
    CMD_ERASE_PREP = 8'hF3,
    CMD_ERASE_UNIT = 8'hF4,
    CMD_FREEZE     = 8'hF5,
    CMD_DISABLE    = 8'hF6
  } sec_cmd_e;

  typedef struct packed {
    logic wr_master;
    logic wr_user;
    logic clr_user;
  } nv_op_t;

  localparam logic [7:0] BLANK_BYTE = 8'h20;
endpackage

// File: rtl/pw_lock_nv.sv
module pw_lock_nv
  import pw_lock_pkg::*;
#(
  parameter int PW_BYTES = 8,
  localparam int PW_W = PW_BYTES * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  nv_op_t          op_i,
  input  logic [PW_W-1:0] pw_i,
  input  logic            level_i,
  output logic [PW_W-1:0] master_o,
  output logic [PW_W-1:0] user_o,
  output logic            lock_en_o,
  output logic            level_max_o
);
  // survives por_i; only rst_ni restores factory content
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_o    <= {PW_BYTES{BLANK_BYTE}};
      user_o      <= '0;
      lock_en_o   <= 1'b0;
      level_max_o <= 1'b0;
    end else begin
      if (op_i.wr_master) master_o <= pw_i;
      if (op_i.wr_user) begin
        user_o      <= pw_i;
        lock_en_o   <= 1'b1;
        level_max_o <= level_i;
      end else if (op_i.clr_user) begin
        user_o    <= '0;
        lock_en_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pw_lock_cmp.sv
module pw_lock_cmp #(
  parameter int PW_BYTES = 8,
  localparam int PW_W = PW_BYTES * 8
) (
  input  logic [PW_W-1:0] a_i,
  input  logic [PW_W-1:0] b_i,
  output logic            hit_o
);
  logic [PW_BYTES-1:0] byte_eq;

  for (genvar g = 0; g < PW_BYTES; g++) begin : g_byte
    assign byte_eq[g] = (a_i[g*8 +: 8] == b_i[g*8 +: 8]);
  end

  assign hit_o = &byte_eq;
endmodule

// File: rtl/pw_lock_seq.sv
module pw_lock_seq
  import pw_lock_pkg::*;
#(
  parameter int MAX_TRIES = 5,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_code_i,
  input  logic             sel_master_i,
  input  logic             lock_en_i,
  input  logic             level_max_i,
  input  logic             hit_user_i,
  input  logic             hit_master_i,
  output nv_op_t           nv_op_o,
  output logic             locked_o,
  output logic             frozen_o,
  output logic             prep_o,
  output logic [CNT_W-1:0] fails_o,
  output logic             done_o,
  output logic             abort_o,
  output logic             erase_o
);
  logic   fire, at_limit, hit_any, hit_strict;
  logic   ok, bad_pw, erase_d, nxt_locked, nxt_frozen, nxt_prep;
  nv_op_t op;

  assign fire       = cmd_valid_i && !por_i;
  assign at_limit   = (fails_o >= CNT_W'(MAX_TRIES));
  assign hit_any    = sel_master_i ? hit_master_i : hit_user_i;
  // master credential is refused for unlock/disable at Maximum level
  assign hit_strict = sel_master_i ? (hit_master_i && !level_max_i) : hit_user_i;

  always_comb begin
    ok         = 1'b0;
    bad_pw     = 1'b0;
    erase_d    = 1'b0;
    op         = '0;
    nxt_locked = locked_o;
    nxt_frozen = frozen_o;
    nxt_prep   = 1'b0;
    case (cmd_code_i)
      CMD_SET_PW: begin
        if (!frozen_o && !locked_o) begin
          ok           = 1'b1;
          op.wr_master = sel_master_i;
          op.wr_user   = !sel_master_i;
        end
      end
      CMD_UNLOCK: begin
        if (!frozen_o && !at_limit) begin
          if (hit_strict) begin
            ok         = 1'b1;
            nxt_locked = 1'b0;
          end else begin
            bad_pw = 1'b1;
          end
        end
      end
      CMD_ERASE_PREP: begin
        if (!frozen_o) begin
          ok       = 1'b1;
          nxt_prep = 1'b1;
        end
      end
      CMD_ERASE_UNIT: begin
        if (!frozen_o && prep_o) begin
          if (hit_any) begin
            ok          = 1'b1;
            erase_d     = 1'b1;
            op.clr_user = 1'b1;
            nxt_locked  = 1'b0;
          end else begin
            bad_pw = 1'b1;
          end
        end
      end
      CMD_FREEZE: begin
        if (!locked_o) begin
          ok         = 1'b1;
          nxt_frozen = 1'b1;
        end
      end
      CMD_DISABLE: begin
        if (!frozen_o && !locked_o) begin
          if (hit_strict) begin
            ok          = 1'b1;
            op.clr_user = 1'b1;
          end else begin
            bad_pw = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign nv_op_o = fire ? op : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      frozen_o <= 1'b0;
      prep_o   <= 1'b0;
      fails_o  <= '0;
      done_o   <= 1'b0;
      abort_o  <= 1'b0;
      erase_o  <= 1'b0;
    end else if (por_i) begin
      locked_o <= lock_en_i;
      frozen_o <= 1'b0;
      prep_o   <= 1'b0;
      fails_o  <= '0;
      done_o   <= 1'b0;
      abort_o  <= 1'b0;
      erase_o  <= 1'b0;
    end else if (fire) begin
      locked_o <= nxt_locked;
      frozen_o <= nxt_frozen;
      prep_o   <= nxt_prep;
      if (bad_pw && !at_limit) fails_o <= fails_o + CNT_W'(1);
      done_o   <= ok;
      abort_o  <= !ok;
      erase_o  <= erase_d;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      erase_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pw_lock_ctrl.sv
module pw_lock_ctrl
  import pw_lock_pkg::*;
#(
  parameter int PW_BYTES  = 8,
  parameter int MAX_TRIES = 5,
  localparam int PW_W  = PW_BYTES * 8,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            por_i,
  input  logic            cmd_valid_i,
  input  logic [7:0]      cmd_code_i,
  input  logic [PW_W-1:0] pw_i,
  input  logic            sel_master_i,
  input  logic            level_max_i,
  output logic            media_ok_o,
  output logic            done_o,
  output logic            abort_o,
  output logic            erase_req_o
);
  nv_op_t           nv_op;
  logic [PW_W-1:0]  master_pw, user_pw;
  logic             lock_en, level_max, hit_user, hit_master;
  logic             locked, frozen, prep;
  logic [CNT_W-1:0] fails;

  pw_lock_nv #(.PW_BYTES(PW_BYTES)) u_nv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (nv_op),
    .pw_i        (pw_i),
    .level_i     (level_max_i),
    .master_o    (master_pw),
    .user_o      (user_pw),
    .lock_en_o   (lock_en),
    .level_max_o (level_max)
  );

  pw_lock_cmp #(.PW_BYTES(PW_BYTES)) u_cmp_user (
    .a_i   (pw_i),
    .b_i   (user_pw),
    .hit_o (hit_user)
  );

  pw_lock_cmp #(.PW_BYTES(PW_BYTES)) u_cmp_master (
    .a_i   (pw_i),
    .b_i   (master_pw),
    .hit_o (hit_master)
  );

  pw_lock_seq #(.MAX_TRIES(MAX_TRIES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_i        (por_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_code_i   (cmd_code_i),
    .sel_master_i (sel_master_i),
    .lock_en_i    (lock_en),
    .level_max_i  (level_max),
    .hit_user_i   (hit_user),
    .hit_master_i (hit_master),
    .nv_op_o      (nv_op),
    .locked_o     (locked),
    .frozen_o     (frozen),
    .prep_o       (prep),
    .fails_o      (fails),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .erase_o      (erase_req_o)
  );

  assign media_ok_o = !locked;
endmodule

// File: rtl/pw_lock_chk.sv
module pw_lock_chk
  import pw_lock_pkg::*;
#(
  parameter int MAX_TRIES = 5,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_i,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_code_i,
  input logic             sel_master_i,
  input logic             media_ok_o,
  input logic             done_o,
  input logic             abort_o,
  input logic             erase_req_o,
  input logic             lock_en,
  input logic             level_max,
  input logic             frozen,
  input logic             prep,
  input logic [CNT_W-1:0] fails
);
  logic fire;
  assign fire = cmd_valid_i && !por_i;

  p_ack_once_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> $onehot({done_o, abort_o}));

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !done_o && !abort_o && !erase_req_o);

  p_por_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i && lock_en |=> !media_ok_o);

  p_user_set_defers_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_code_i == CMD_SET_PW && !sel_master_i && media_ok_o |=> media_ok_o);

  p_max_master_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_code_i == CMD_UNLOCK && sel_master_i && level_max |=> abort_o);

  p_erase_needs_prep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_code_i == CMD_ERASE_UNIT && !prep |=> abort_o && !erase_req_o);

  p_erase_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> done_o && media_ok_o);

  p_frozen_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && frozen && (cmd_code_i == CMD_SET_PW || cmd_code_i == CMD_UNLOCK ||
      cmd_code_i == CMD_ERASE_PREP || cmd_code_i == CMD_ERASE_UNIT ||
      cmd_code_i == CMD_DISABLE) |=> abort_o);

  p_try_limit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_code_i == CMD_UNLOCK && fails >= CNT_W'(MAX_TRIES) |=> abort_o);
endmodule

bind pw_lock_ctrl pw_lock_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_i        (por_i),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_code_i   (cmd_code_i),
  .sel_master_i (sel_master_i),
  .media_ok_o   (media_ok_o),
  .done_o       (done_o),
  .abort_o      (abort_o),
  .erase_req_o  (erase_req_o),
  .lock_en      (lock_en),
  .level_max    (level_max),
  .frozen       (frozen),
  .prep         (prep),
  .fails        (fails)
);

// File: tb/pw_lock_ctrl_bench.sv
module pw_lock_ctrl_bench;
  localparam int PW_BYTES = 8;
  localparam int PW_W = PW_BYTES * 8;

  localparam logic [7:0] C_SET = 8'hF1, C_UNL = 8'hF2, C_PRE = 8'hF3,
                         C_ERA = 8'hF4, C_FRZ = 8'hF5, C_DIS = 8'hF6;
  localparam logic [PW_W-1:0] PW_BLANK = {PW_BYTES{8'h20}};
  localparam logic [PW_W-1:0] PW_M = 64'h4D41_5354_4552_2131;
  localparam logic [PW_W-1:0] PW_U = 64'h7573_6572_5f70_7721;
  localparam logic [PW_W-1:0] PW_X = 64'hDEAD_BEEF_0BAD_F00D;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [7:0] cmd_code_i = '0;
  logic [PW_W-1:0] pw_i = '0;
  logic sel_master_i = 1'b0;
  logic level_max_i = 1'b0;
  logic media_ok_o, done_o, abort_o, erase_req_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pw_lock_ctrl #(.PW_BYTES(PW_BYTES), .MAX_TRIES(5)) u_pw_lock_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .por_i        (por_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_code_i   (cmd_code_i),
    .pw_i         (pw_i),
    .sel_master_i (sel_master_i),
    .level_max_i  (level_max_i),
    .media_ok_o   (media_ok_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .erase_req_o  (erase_req_o)
  );

  task automatic check(string tag, logic d, logic a, logic e, logic m);
    total++;
    if ({done_o, abort_o, erase_req_o, media_ok_o} !== {d, a, e, m}) begin
      bad++;
      $display("FAIL %s: got done/abort/erase/media=%b%b%b%b exp=%b%b%b%b",
               tag, done_o, abort_o, erase_req_o, media_ok_o, d, a, e, m);
    end
  endtask

  // drive at negedge, response registered at the next posedge, sampled at the following negedge
  task automatic issue(logic [7:0] code, logic [PW_W-1:0] pw, logic sel, logic lvl);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_code_i = code; pw_i = pw; sel_master_i = sel; level_max_i = lvl;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic power_on();
    @(negedge clk);
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset state", 0, 0, 0, 1);

    // R1 exhaustive sweep of undefined codes
    for (int c = 0; c < 256; c++) begin
      if (c < 8'hF1 || c > 8'hF6) begin
        issue(8'(c), PW_X, 1'b0, 1'b0);
        check("R1 undefined code aborts", 0, 1, 0, 1);
      end
    end
    @(negedge clk);
    check("R12 no pulse without command", 0, 0, 0, 1);

    issue(C_DIS, PW_BLANK, 1'b1, 1'b0);
    check("R1 factory master blank accepted", 1, 0, 0, 1);
    @(negedge clk);
    check("R12 single cycle pulse", 0, 0, 0, 1);

    issue(C_SET, PW_M, 1'b1, 1'b0);
    check("R2 set master", 1, 0, 0, 1);
    power_on();
    check("R2 master set leaves unlocked", 0, 0, 0, 1);
    issue(C_DIS, PW_BLANK, 1'b1, 1'b0);
    check("R2 old master replaced", 0, 1, 0, 1);

    issue(C_SET, PW_U, 1'b0, 1'b0);
    check("R3 set user, not yet locked", 1, 0, 0, 1);
    power_on();
    check("R3 locked after power-on", 0, 0, 0, 0);

    issue(C_SET, PW_X, 1'b0, 1'b0);
    check("R4 set while locked", 0, 1, 0, 0);
    issue(C_FRZ, PW_X, 1'b0, 1'b0);
    check("R4 freeze while locked", 0, 1, 0, 0);
    issue(C_DIS, PW_U, 1'b0, 1'b0);
    check("R4 disable while locked", 0, 1, 0, 0);

    issue(C_UNL, PW_X, 1'b0, 1'b0);
    check("R10 wrong user unlock", 0, 1, 0, 0);
    issue(C_UNL, PW_U, 1'b0, 1'b0);
    check("R5 user unlock", 1, 0, 0, 1);

    power_on();
    check("R5 relocked", 0, 0, 0, 0);
    issue(C_UNL, PW_M, 1'b1, 1'b0);
    check("R5 master unlock at High", 1, 0, 0, 1);

    // Maximum level recovery
    issue(C_SET, PW_U, 1'b0, 1'b1);
    check("R3 set user at Maximum", 1, 0, 0, 1);
    power_on();
    check("R3 locked at Maximum", 0, 0, 0, 0);
    issue(C_UNL, PW_M, 1'b1, 1'b0);
    check("R6 master unlock at Maximum", 0, 1, 0, 0);
    issue(C_ERA, PW_M, 1'b1, 1'b0);
    check("R7 erase without prepare", 0, 1, 0, 0);
    issue(C_PRE, PW_X, 1'b1, 1'b0);
    check("R7 prepare", 1, 0, 0, 0);
    issue(C_FRZ, PW_X, 1'b0, 1'b0);
    check("R7 intervening command", 0, 1, 0, 0);
    issue(C_ERA, PW_M, 1'b1, 1'b0);
    check("R7 prepare cancelled", 0, 1, 0, 0);
    issue(C_PRE, PW_X, 1'b1, 1'b0);
    check("R7 prepare again", 1, 0, 0, 0);
    issue(C_ERA, PW_M, 1'b1, 1'b0);
    check("R8 master erase unit", 1, 0, 1, 1);
    power_on();
    check("R8 lock removed by erase", 0, 0, 0, 1);

    // freeze
    issue(C_FRZ, PW_X, 1'b0, 1'b0);
    check("R9 freeze", 1, 0, 0, 1);
    issue(C_SET, PW_U, 1'b0, 1'b0);
    check("R9 set while frozen", 0, 1, 0, 1);
    issue(C_UNL, PW_M, 1'b1, 1'b0);
    check("R9 unlock while frozen", 0, 1, 0, 1);
    issue(C_PRE, PW_X, 1'b0, 1'b0);
    check("R9 prepare while frozen", 0, 1, 0, 1);
    issue(C_ERA, PW_M, 1'b1, 1'b0);
    check("R9 erase while frozen", 0, 1, 0, 1);
    issue(C_DIS, PW_M, 1'b1, 1'b0);
    check("R9 disable while frozen", 0, 1, 0, 1);
    power_on();
    issue(C_SET, PW_U, 1'b0, 1'b0);
    check("R9 freeze cleared by power-on", 1, 0, 0, 1);

    // attempt limit
    power_on();
    check("R10 locked", 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      issue(C_UNL, PW_X, 1'b0, 1'b0);
      check("R10 failed attempt", 0, 1, 0, 0);
    end
    issue(C_UNL, PW_U, 1'b0, 1'b0);
    check("R10 limit blocks correct password", 0, 1, 0, 0);
    power_on();
    issue(C_UNL, PW_U, 1'b0, 1'b0);
    check("R10 counter cleared by power-on", 1, 0, 0, 1);

    // disable
    issue(C_DIS, PW_X, 1'b0, 1'b0);
    check("R11 disable wrong password", 0, 1, 0, 1);
    issue(C_DIS, PW_U, 1'b0, 1'b0);
    check("R11 disable user", 1, 0, 0, 1);
    power_on();
    check("R11 stays unlocked", 0, 0, 0, 1);
    issue(C_SET, PW_U, 1'b0, 1'b1);
    check("R11 set user at Maximum", 1, 0, 0, 1);
    issue(C_DIS, PW_M, 1'b1, 1'b0);
    check("R11 master disable at Maximum", 0, 1, 0, 1);
    issue(C_PRE, PW_X, 1'b0, 1'b0);
    check("R8 prepare", 1, 0, 0, 1);
    issue(C_ERA, PW_U, 1'b0, 1'b0);
    check("R8 user erase unit", 1, 0, 1, 1);
    power_on();
    check("R8 lock removed by user erase", 0, 0, 0, 1);

    // command together with power-on is dropped
    @(negedge clk);
    por_i = 1'b1; cmd_valid_i = 1'b1; cmd_code_i = C_FRZ;
    @(negedge clk);
    por_i = 1'b0; cmd_valid_i = 1'b0;
    check("R12 command with por dropped", 0, 0, 0, 1);
    issue(C_SET, PW_U, 1'b0, 1'b0);
    check("R12 dropped freeze had no effect", 1, 0, 0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule